// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences the operating modes of a small processor. It holds one of five power modes, plus a transient reboot state, and decodes that state into enables for the PLL, the PLL bypass path, the core clock and the system clock. It also drives a core-supply request and a regulator-wake line, and it issues a hardware-reset pulse. Software asks for a new mode through a request port. Wake sources bring the processor back, and which mode it returns to depends on the mode being left, on the bypass control bit and on the wake source.

There are two kinds of wake source. Synchronous system wake lines serve the light sleep mode. Asynchronous GPIO pins serve the two deepest states, and each pin passes through a two-flop synchronizer and a consecutive-sample glitch filter. A wake from hibernate never resumes the processor: it always runs the hardware-reset pulse and then enters full-on. The wake-enable configuration register survives hibernate and the reset pulse. Only the power-on reset `rstN` clears it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstN` is low and after it is released, the mode is FULL (code 0) and both wake-enable masks are zero.
- R2: The outputs depend on the mode code as follows. FULL=0: PLL on, no bypass, both clocks on. ACTIVE=1: bypass on, both clocks on, PLL enable equal to ACTIVE_PLL_ON. SLEEP=2: PLL on, core clock off, system clock on. DEEP=3: PLL and both clocks off. HIBER=4: everything off, `coreOn`=0 and `extWake`=0. REBOOT=5: PLL on, clocks off, `hwResetReq`=1. `coreOn` and `extWake` are 1 in every mode except HIBER.
- R3: In FULL or ACTIVE, a request with code 0 to 4 sets the mode to that code on the next clock edge. Codes 5 to 7 are ignored.
- R4: Mode requests made in SLEEP, DEEP, HIBER or REBOOT are ignored.
- R5: In SLEEP, a `sysWake` bit whose enable is set moves the mode to ACTIVE if `bypassSel`=1 and to FULL if `bypassSel`=0, one edge later. A `sysWake` bit whose enable is clear has no effect.
- R6: `dmaGrant` equals `dmaReq` in FULL and ACTIVE and is 0 in every other mode.
- R7: In DEEP, `resetEvt` moves the mode to FULL on the next edge. A qualified GPIO wake moves it to ACTIVE.
- R8: A GPIO pin is qualified once its synchronised level has been high for WAKE_FILT consecutive cycles and its enable bit is set. A pin driven high for exactly WAKE_FILT cycles wakes DEEP on edge WAKE_FILT+3 after it rose. A pin driven high for WAKE_FILT-1 cycles, or a pin whose enable is clear, causes no wake.
- R9: In HIBER, `resetEvt` or a qualified GPIO wake moves the mode to REBOOT.
- R10: REBOOT lasts exactly RST_CYCLES cycles with `hwResetReq` high, and is followed by FULL.
- R11: The wake-enable masks keep their value through HIBER and REBOOT.
- R12: In FULL, ACTIVE or SLEEP, `resetEvt` moves the mode to REBOOT. It takes priority over a mode request or a wake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| resetEvt | input | 1 | External reset event, synchronous |
| modeReqValid | input | 1 | Mode request strobe |
| modeReq | input | 3 | Requested mode code |
| bypassSel | input | 1 | PLL bypass control bit, sampled on sleep exit |
| cfgWr | input | 1 | Write strobe for the wake-enable register |
| cfgGpioEn | input | NGPIO | GPIO wake enables to write |
| cfgSysEn | input | NSYS | System wake enables to write |
| sysWake | input | NSYS | Synchronous wake sources for sleep |
| gpioWake | input | NGPIO | Asynchronous GPIO wake pins |
| dmaReq | input | 1 | DMA request for local memory |
| modeStatus | output | 3 | Current mode code |
| pllEn | output | 1 | PLL enable |
| pllBypass | output | 1 | PLL bypass select |
| cclkEn | output | 1 | Core clock enable |
| sclkEn | output | 1 | System clock enable |
| coreOn | output | 1 | Core supply request |
| extWake | output | 1 | Regulator wake line, low in hibernate |
| hwResetReq | output | 1 | Hardware reset pulse |
| dmaGrant | output | 1 | DMA grant to local memory |

## Verification
Reset and wake handling can land in the same cycle. The bench raises `resetEvt` together with a mode request in FULL, and together with an enabled system wake in SLEEP. In both cases it expects the next mode to be REBOOT rather than the target of the request or of the wake. It also raises reset in DEEP, where the expected result is a direct move to FULL and not a reboot pulse.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    MODE_FULL   = 3'd0,
    MODE_ACTIVE = 3'd1,
    MODE_SLEEP  = 3'd2,
    MODE_DEEP   = 3'd3,
    MODE_HIBER  = 3'd4,
    MODE_REBOOT = 3'd5
  } pwrMode_t;

  typedef struct packed {
    logic rebootLoad;
    logic rebootStep;
  } ctlStrobe_t;

  typedef struct packed {
    logic gpioHit;
    logic sysHit;
    logic rebootDone;
  } dpFlag_t;
endpackage

// File: rtl/pwr_wake_path.sv
module pwr_wake_path
  import pwr_mode_pkg::*;
#(
  parameter int NGPIO      = 4,
  parameter int NSYS       = 3,
  parameter int WAKE_FILT  = 4,
  parameter int RST_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             cfgWr,
  input  logic [NGPIO-1:0] cfgGpioEn,
  input  logic [NSYS-1:0]  cfgSysEn,
  input  logic [NSYS-1:0]  sysWake,
  input  logic [NGPIO-1:0] gpioWake,
  output dpFlag_t          flags
);
  localparam int FW = $clog2(WAKE_FILT + 1);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [FW-1:0] FILT_MAX = FW'(WAKE_FILT);
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_CYCLES - 1);

  logic [NGPIO-1:0] gpioEnReg;
  logic [NSYS-1:0]  sysEnReg;
  logic [NGPIO-1:0] pinQual;
  logic [RW-1:0]    rebootCnt;

  // retained configuration: only power-on reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpioEnReg <= '0;
      sysEnReg  <= '0;
    end else if (cfgWr) begin
      gpioEnReg <= cfgGpioEn;
      sysEnReg  <= cfgSysEn;
    end
  end

  for (genvar p = 0; p < NGPIO; p++) begin : g_pin
    logic syncA, syncB;
    logic [FW-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA  <= 1'b0;
        syncB  <= 1'b0;
        runCnt <= '0;
      end else begin
        syncA <= gpioWake[p];
        syncB <= syncA;
        if (!syncB)                runCnt <= '0;
        else if (runCnt != FILT_MAX) runCnt <= runCnt + 1'b1;
      end
    end
    assign pinQual[p] = (runCnt == FILT_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                rebootCnt <= '0;
    else if (strobe.rebootLoad)               rebootCnt <= RST_LOAD;
    else if (strobe.rebootStep && rebootCnt != '0) rebootCnt <= rebootCnt - 1'b1;
  end

  assign flags.gpioHit    = |(pinQual & gpioEnReg);
  assign flags.sysHit     = |(sysWake & sysEnReg);
  assign flags.rebootDone = (rebootCnt == '0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter bit ACTIVE_PLL_ON = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpFlag_t    flags,
  input  logic       resetEvt,
  input  logic       modeReqValid,
  input  logic [2:0] modeReq,
  input  logic       bypassSel,
  input  logic       dmaReq,
  output ctlStrobe_t strobe,
  output logic [2:0] modeStatus,
  output logic       pllEn,
  output logic       pllBypass,
  output logic       cclkEn,
  output logic       sclkEn,
  output logic       coreOn,
  output logic       extWake,
  output logic       hwResetReq,
  output logic       dmaGrant
);
  pwrMode_t mode, nextMode;
  logic     loadReboot;

  always_comb begin
    nextMode   = mode;
    loadReboot = 1'b0;
    if (resetEvt && mode != MODE_REBOOT) begin
      if (mode == MODE_DEEP) nextMode = MODE_FULL;
      else begin
        nextMode   = MODE_REBOOT;
        loadReboot = 1'b1;
      end
    end else begin
      unique case (mode)
        MODE_FULL, MODE_ACTIVE:
          if (modeReqValid && modeReq <= 3'd4) nextMode = pwrMode_t'(modeReq);
        MODE_SLEEP:
          if (flags.sysHit) nextMode = bypassSel ? MODE_ACTIVE : MODE_FULL;
        MODE_DEEP:
          if (flags.gpioHit) nextMode = MODE_ACTIVE;
        MODE_HIBER:
          if (flags.gpioHit) begin
            nextMode   = MODE_REBOOT;
            loadReboot = 1'b1;
          end
        MODE_REBOOT:
          if (flags.rebootDone) nextMode = MODE_FULL;
        default: nextMode = MODE_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_FULL;
    else       mode <= nextMode;
  end

  assign strobe.rebootLoad = loadReboot;
  assign strobe.rebootStep = (mode == MODE_REBOOT);

  always_comb begin
    pllEn = 1'b0; pllBypass = 1'b0; cclkEn = 1'b0; sclkEn = 1'b0;
    coreOn = 1'b1; extWake = 1'b1;
    unique case (mode)
      MODE_FULL:   begin pllEn = 1'b1; cclkEn = 1'b1; sclkEn = 1'b1; end
      MODE_ACTIVE: begin pllEn = ACTIVE_PLL_ON; pllBypass = 1'b1; cclkEn = 1'b1; sclkEn = 1'b1; end
      MODE_SLEEP:  begin pllEn = 1'b1; sclkEn = 1'b1; end
      MODE_DEEP:   ;
      MODE_HIBER:  begin coreOn = 1'b0; extWake = 1'b0; end
      MODE_REBOOT: pllEn = 1'b1;
      default:     ;
    endcase
  end

  assign modeStatus = mode;
  assign hwResetReq = (mode == MODE_REBOOT);
  assign dmaGrant   = dmaReq && (mode == MODE_FULL || mode == MODE_ACTIVE);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NGPIO         = 4,
  parameter int NSYS          = 3,
  parameter int WAKE_FILT     = 4,
  parameter int RST_CYCLES    = 6,
  parameter bit ACTIVE_PLL_ON = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetEvt,
  input  logic             modeReqValid,
  input  logic [2:0]       modeReq,
  input  logic             bypassSel,
  input  logic             cfgWr,
  input  logic [NGPIO-1:0] cfgGpioEn,
  input  logic [NSYS-1:0]  cfgSysEn,
  input  logic [NSYS-1:0]  sysWake,
  input  logic [NGPIO-1:0] gpioWake,
  input  logic             dmaReq,
  output logic [2:0]       modeStatus,
  output logic             pllEn,
  output logic             pllBypass,
  output logic             cclkEn,
  output logic             sclkEn,
  output logic             coreOn,
  output logic             extWake,
  output logic             hwResetReq,
  output logic             dmaGrant
);
  ctlStrobe_t strobe;
  dpFlag_t    flags;

  pwr_wake_path #(
    .NGPIO(NGPIO), .NSYS(NSYS), .WAKE_FILT(WAKE_FILT), .RST_CYCLES(RST_CYCLES)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWr(cfgWr),
    .cfgGpioEn(cfgGpioEn), .cfgSysEn(cfgSysEn), .sysWake(sysWake),
    .gpioWake(gpioWake), .flags(flags)
  );

  pwr_mode_fsm #(.ACTIVE_PLL_ON(ACTIVE_PLL_ON)) u_fsm (
    .clk(clk), .rstN(rstN), .flags(flags), .resetEvt(resetEvt),
    .modeReqValid(modeReqValid), .modeReq(modeReq), .bypassSel(bypassSel),
    .dmaReq(dmaReq), .strobe(strobe), .modeStatus(modeStatus),
    .pllEn(pllEn), .pllBypass(pllBypass), .cclkEn(cclkEn), .sclkEn(sclkEn),
    .coreOn(coreOn), .extWake(extWake), .hwResetReq(hwResetReq),
    .dmaGrant(dmaGrant)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int RST_CYCLES = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] modeStatus,
  input logic       cclkEn,
  input logic       coreOn,
  input logic       extWake,
  input logic       hwResetReq,
  input logic       dmaGrant
);
  int rstRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rstRun <= 0;
    else if (hwResetReq) rstRun <= rstRun + 1;
    else                rstRun <= 0;
  end

  a_r10_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    (!hwResetReq && rstRun != 0) |-> (rstRun == RST_CYCLES));
  a_r10_then_full: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hwResetReq) |-> (modeStatus == 3'd0));
  a_r6_no_grant_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 3'd2) |-> !dmaGrant);
  a_r9_hiber_power: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 3'd4) |-> (!coreOn && !extWake));
  a_r7_deep_exit: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeStatus) == 3'd3 && modeStatus != 3'd3) |-> (modeStatus <= 3'd1));
  a_r2_cclk_modes: assert property (@(posedge clk) disable iff (!rstN)
    cclkEn |-> (modeStatus <= 3'd1));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .modeStatus(modeStatus), .cclkEn(cclkEn),
  .coreOn(coreOn), .extWake(extWake), .hwResetReq(hwResetReq),
  .dmaGrant(dmaGrant)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int G = 4;
  localparam int R = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0, resetEvt = 1'b0, modeReqValid = 1'b0, bypassSel = 1'b0;
  logic [2:0] modeReq = '0;
  logic cfgWr = 1'b0, dmaReq = 1'b1;
  logic [3:0] cfgGpioEn = '0, gpioWake = '0;
  logic [2:0] cfgSysEn = '0, sysWake = '0;
  logic [2:0] modeStatus;
  logic pllEn, pllBypass, cclkEn, sclkEn, coreOn, extWake, hwResetReq, dmaGrant;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { string tag; logic [10:0] val; } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .resetEvt(resetEvt), .modeReqValid(modeReqValid),
    .modeReq(modeReq), .bypassSel(bypassSel), .cfgWr(cfgWr),
    .cfgGpioEn(cfgGpioEn), .cfgSysEn(cfgSysEn), .sysWake(sysWake),
    .gpioWake(gpioWake), .dmaReq(dmaReq), .modeStatus(modeStatus),
    .pllEn(pllEn), .pllBypass(pllBypass), .cclkEn(cclkEn), .sclkEn(sclkEn),
    .coreOn(coreOn), .extWake(extWake), .hwResetReq(hwResetReq),
    .dmaGrant(dmaGrant)
  );

  // expected output vector {mode, pll, byp, cclk, sclk, core, ext, rst, grant}
  function automatic logic [10:0] expect_of(input logic [2:0] m);
    case (m)
      3'd0: return {m, 8'b1011_1101};
      3'd1: return {m, 8'b1111_1101};
      3'd2: return {m, 8'b1001_1100};
      3'd3: return {m, 8'b0000_1100};
      3'd4: return {m, 8'b0000_0000};
      default: return {m, 8'b1000_1110};
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input string tag, input logic [2:0] m);
    item_t it;
    it.tag = tag;
    it.val = expect_of(m);
    expQ.push_back(it);
  endtask

  task automatic req(input logic [2:0] code);
    modeReqValid = 1'b1; modeReq = code;
    tick(1);
    modeReqValid = 1'b0;
  endtask

  // monitor: compare queued expectations against outputs at falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        item_t it;
        logic [10:0] act;
        it = expQ.pop_front();
        act = {modeStatus, pllEn, pllBypass, cclkEn, sclkEn, coreOn, extWake, hwResetReq, dmaGrant};
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s actual %b expected %b", it.tag, act, it.val);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    push("R1 reset state", 3'd0);
    rstN = 1'b1;
    tick(1);
    push("R1 after release", 3'd0);

    req(3'd7);                      push("R3 bad code ignored", 3'd0);
    req(3'd1);                      push("R3 R2 to active", 3'd1);
    req(3'd2);                      push("R2 R6 sleep no grant", 3'd2);
    req(3'd0);                      push("R4 request in sleep", 3'd2);
    sysWake = 3'b001; tick(1); sysWake = '0;
    push("R5 disabled wake", 3'd2);

    cfgWr = 1'b1; cfgSysEn = 3'b001; cfgGpioEn = 4'b0010; tick(1); cfgWr = 1'b0;
    bypassSel = 1'b1; sysWake = 3'b001; tick(1); sysWake = '0;
    push("R5 bypass set to active", 3'd1);
    req(3'd2); bypassSel = 1'b0; sysWake = 3'b001; tick(1); sysWake = '0;
    push("R5 bypass clear to full", 3'd0);

    req(3'd3);                      push("R2 deep", 3'd3);
    gpioWake = 4'b0010; tick(G - 1); gpioWake = '0; tick(6);
    push("R8 short pulse rejected", 3'd3);
    gpioWake = 4'b0001; tick(G + 6); gpioWake = '0; tick(4);
    push("R8 disabled pin", 3'd3);
    gpioWake = 4'b0010; tick(G + 2);
    push("R8 not yet qualified", 3'd3);
    tick(1);
    push("R7 R8 gpio wake to active", 3'd1);
    gpioWake = '0; tick(4);

    req(3'd3);
    resetEvt = 1'b1; tick(1); resetEvt = 1'b0;
    push("R7 reset from deep", 3'd0);

    req(3'd4);                      push("R9 hibernate", 3'd4);
    req(3'd0);                      push("R4 request in hibernate", 3'd4);
    resetEvt = 1'b1; tick(1); resetEvt = 1'b0;
    push("R9 reset wakes to reboot", 3'd5);
    for (int i = 1; i < R; i++) begin
      tick(1); push("R10 reboot held", 3'd5);
    end
    tick(1);                        push("R10 reboot to full", 3'd0);

    req(3'd4);
    gpioWake = 4'b0010; tick(G + 3);
    push("R11 R9 retained gpio enable", 3'd5);
    gpioWake = '0;
    tick(R - 1);                    push("R10 still reboot", 3'd5);
    tick(1);                        push("R10 full after gpio reboot", 3'd0);

    resetEvt = 1'b1; modeReqValid = 1'b1; modeReq = 3'd2; tick(1);
    resetEvt = 1'b0; modeReqValid = 1'b0;
    push("R12 reset beats request", 3'd5);
    tick(R);
    req(3'd2);
    resetEvt = 1'b1; sysWake = 3'b001; tick(1); resetEvt = 1'b0; sysWake = '0;
    push("R12 reset beats sleep wake", 3'd5);
    tick(R);                        push("R12 back to full", 3'd0);

    rstN = 1'b0; tick(2); rstN = 1'b1; tick(1);
    req(3'd3);
    gpioWake = 4'b0010; tick(G + 6); gpioWake = '0;
    push("R1 masks cleared by power-on reset", 3'd3);
    resetEvt = 1'b1; tick(1); resetEvt = 1'b0;
    push("R7 exit deep", 3'd0);

    @(negedge clk); #1;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule